// File: doc/BRIEF.md
# Sequential Breakpoint and Trace Qualifier

This block sits between two memory-address comparators and the rest of an on-chip debug unit. Every cycle it decides what the comparator match pulses do. A pulse can raise a debug request, arm a later stage of a breakpoint sequence, or freeze the program-counter history FIFO. The block also decides whether the trace counter may count. The decision depends on a 2-bit sequencing mode, which can make comparator A a prerequisite for comparator B, make B a prerequisite for trace counting, or chain A, then B, then trace. A comparator that only arms a later stage raises no request of its own.

The block also merges the other debug request sources into one registered request line: a forced-debug control bit, an internal request line gated by its enable bit, and the trace counter's terminal pulse. It keeps the sticky freeze status that holds the PC FIFO until software clears it. The comparators, the trace counter datapath, the FIFO storage and the test-port access are outside the block.

Top module: `bkpt_seq_top`

## Requirements
- R1: After reset, `dbgReq`, `fifoFreeze` and `freezeFlag` are 0, and both arming flags are clear.
- R2: With `seqMode` = 2'b00, a `matchA` pulse drives `dbgReq` high in the following cycle. A `matchB` pulse does the same when `freezeSel` = 0. `traceCntEn` equals `traceEn`.
- R3: With `seqMode` = 2'b01, `matchB` raises no request, while `matchA` still does. `traceCntEn` stays 0 until the cycle after the first `matchB`, and from then on it follows `traceEn`.
- R4: With `seqMode` = 2'b10, `matchA` raises no request and arms B. A `matchB` before that arming, or in the same cycle as it, is ignored. After arming, `matchB` behaves as in R2.
- R5: With `seqMode` = 2'b11, neither match raises a request or a freeze. `traceCntEn` goes high, if `traceEn` = 1, from the cycle after a `matchB` that follows an earlier armed `matchA`. A `matchB` in the same cycle as the arming `matchA` does not count.
- R6: While `traceEn` = 0, `traceCntEn` is 0 in every mode.
- R7: With `freezeSel` = 1, a qualified B match raises no request. Instead, it sets `freezeFlag` and `fifoFreeze` in the following cycle.
- R8: Freeze status is sticky until a cycle with `freezeClr` = 1, after which it reads 0. If a new freeze and a clear arrive in the same cycle, the freeze wins.
- R9: While `forceDbg` = 1, `dbgReq` is 1 in every following cycle. It drops one cycle after `forceDbg` clears.
- R10: `intReq` raises `dbgReq` in the next cycle only when `intReqEn` = 1.
- R11: `traceTerm` raises `dbgReq` in the next cycle only while `traceCntEn` = 1.
- R12: Any change of `seqMode` clears both arming flags. In the cycle where `seqMode` first shows its new value, the flags already read as clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low test-logic reset |
| seqMode | input | 2 | Sequencing mode (00 off, 01 B gates trace, 10 A gates B, 11 A then B gates trace) |
| traceEn | input | 1 | Trace operation enable |
| freezeSel | input | 1 | Qualified B match freezes the PC FIFO instead of requesting debug |
| forceDbg | input | 1 | Unconditional debug request |
| intReqEn | input | 1 | Enable for the internal request line |
| matchA | input | 1 | Comparator A match pulse |
| matchB | input | 1 | Comparator B match pulse |
| traceTerm | input | 1 | Trace counter terminal pulse |
| intReq | input | 1 | Internal debug request line |
| freezeClr | input | 1 | Clears the freeze status |
| dbgReq | output | 1 | Registered debug request |
| traceCntEn | output | 1 | Trace counter enable |
| fifoFreeze | output | 1 | PC FIFO update freeze |
| freezeFlag | output | 1 | Sticky freeze status |

## Verification
`traceCntEn` is combinational from the mode, `traceEn` and the arming flags. The bench therefore samples it in the same cycle as a change of mode or enable. For a change caused by a match, it samples one edge later, because arming a flag takes one register. `dbgReq`, `freezeFlag` and `fifoFreeze` are each one register away from their causes. Inputs are driven on the falling edge, and these outputs are sampled at the next falling edge, which is exactly one rising edge after the stimulus. Every scenario begins from a fresh reset, so earlier arming cannot leak into it.

// File: rtl/bkpt_seq_pkg.sv
package bkpt_seq_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SEQ_OFF       = 2'b00,
    SEQ_B_TRACE   = 2'b01,
    SEQ_A_B       = 2'b10,
    SEQ_A_B_TRACE = 2'b11
  } seq_mode_e;

  // strobes from the sequencing control to the request/freeze datapath
  typedef struct packed {
    logic reqA;     // qualified A request
    logic reqB;     // qualified B request
    logic frzSet;   // qualified B freeze
    logic trcGate;  // trace counting allowed this cycle
  } seq_strobe_t;
endpackage

// File: rtl/bkpt_seq_ctrl.sv
module bkpt_seq_ctrl
  import bkpt_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] seqMode,
  input  logic              traceEn,
  input  logic              freezeSel,
  input  logic              matchA,
  input  logic              matchB,
  output seq_strobe_t       strobe
);
  logic [MODE_W-1:0] modeQ;
  logic armAQ, armBQ;
  logic modeChange, armA, armB;
  logic reqA, qualB, gate, setA, setB;

  // a newly written mode sees cleared arming flags at once (R12)
  assign modeChange = (seqMode != modeQ);
  assign armA = armAQ & ~modeChange;
  assign armB = armBQ & ~modeChange;

  always_comb begin
    reqA  = 1'b0;
    qualB = 1'b0;
    gate  = 1'b1;
    setA  = 1'b0;
    setB  = 1'b0;
    case (seq_mode_e'(seqMode))
      SEQ_OFF: begin
        reqA  = matchA;
        qualB = matchB;
      end
      SEQ_B_TRACE: begin
        reqA = matchA;
        gate = armB;
        setB = matchB;
      end
      SEQ_A_B: begin
        qualB = matchB & armA;
        setA  = matchA;
      end
      SEQ_A_B_TRACE: begin
        gate = armB;
        setA = matchA;
        setB = matchB & armA;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      armAQ <= 1'b0;
      armBQ <= 1'b0;
    end else begin
      modeQ <= seqMode;
      armAQ <= ~modeChange & (armAQ | setA);
      armBQ <= ~modeChange & (armBQ | setB);
    end
  end

  assign strobe.reqA    = reqA;
  assign strobe.reqB    = qualB & ~freezeSel;
  assign strobe.frzSet  = qualB & freezeSel;
  assign strobe.trcGate = traceEn & gate;
endmodule

// File: rtl/bkpt_seq_dp.sv
module bkpt_seq_dp
  import bkpt_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strobe,
  input  logic        forceDbg,
  input  logic        intReqEn,
  input  logic        intReq,
  input  logic        traceTerm,
  input  logic        freezeClr,
  output logic        dbgReqQ,
  output logic        freezeQ
);
  logic reqNext, freezeNext;

  assign reqNext = strobe.reqA | strobe.reqB | forceDbg
                 | (intReqEn & intReq)
                 | (traceTerm & strobe.trcGate);

  // a new freeze wins over a clear in the same cycle
  assign freezeNext = strobe.frzSet | (freezeQ & ~freezeClr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgReqQ <= 1'b0;
      freezeQ <= 1'b0;
    end else begin
      dbgReqQ <= reqNext;
      freezeQ <= freezeNext;
    end
  end
endmodule

// File: rtl/bkpt_seq_top.sv
module bkpt_seq_top
  import bkpt_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] seqMode,
  input  logic              traceEn,
  input  logic              freezeSel,
  input  logic              forceDbg,
  input  logic              intReqEn,
  input  logic              matchA,
  input  logic              matchB,
  input  logic              traceTerm,
  input  logic              intReq,
  input  logic              freezeClr,
  output logic              dbgReq,
  output logic              traceCntEn,
  output logic              fifoFreeze,
  output logic              freezeFlag
);
  seq_strobe_t strobe;
  logic freezeQ;

  bkpt_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .seqMode(seqMode), .traceEn(traceEn),
    .freezeSel(freezeSel), .matchA(matchA), .matchB(matchB), .strobe(strobe)
  );

  bkpt_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .forceDbg(forceDbg),
    .intReqEn(intReqEn), .intReq(intReq), .traceTerm(traceTerm),
    .freezeClr(freezeClr), .dbgReqQ(dbgReq), .freezeQ(freezeQ)
  );

  assign traceCntEn = strobe.trcGate;
  assign fifoFreeze = freezeQ;
  assign freezeFlag = freezeQ;
endmodule

// File: rtl/bkpt_seq_chk.sv
module bkpt_seq_chk
  import bkpt_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] seqMode,
  input logic              traceEn,
  input logic              freezeSel,
  input logic              forceDbg,
  input logic              intReqEn,
  input logic              matchA,
  input logic              matchB,
  input logic              traceTerm,
  input logic              intReq,
  input logic              freezeClr,
  input logic              dbgReq,
  input logic              traceCntEn,
  input logic              fifoFreeze,
  input logic              freezeFlag
);
  // R2
  mode_off_a_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqMode == 2'b00 && matchA) |=> dbgReq);

  // R5
  chained_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqMode == 2'b11 && !forceDbg && !(intReqEn && intReq)
     && !(traceTerm && traceCntEn)) |=> !dbgReq);

  // R6
  trace_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !traceEn |-> !traceCntEn);

  // R7
  freeze_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqMode == 2'b00 && matchB && freezeSel) |=> (freezeFlag && fifoFreeze));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freezeFlag && !freezeClr) |=> freezeFlag);

  // R9
  force_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceDbg |=> dbgReq);

  // R10
  int_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intReqEn && intReq) |=> dbgReq);
endmodule

bind bkpt_seq_top bkpt_seq_chk u_chk (.*);

// File: tb/bkpt_seq_top_bench.sv
module bkpt_seq_top_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] seqMode;
  logic       traceEn, freezeSel, forceDbg, intReqEn;
  logic       matchA, matchB, traceTerm, intReq, freezeClr;
  logic       dbgReq, traceCntEn, fifoFreeze, freezeFlag;

  int nRun  = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bkpt_seq_top u_bkpt_seq_top (.*);

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one rising edge, then back to the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    seqMode = 2'b00; traceEn = 0; freezeSel = 0; forceDbg = 0; intReqEn = 0;
    matchA = 0; matchB = 0; traceTerm = 0; intReq = 0; freezeClr = 0;
    repeat (2) tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "dbgReq", dbgReq, 1'b0);
    chk("R1", "freezeFlag", freezeFlag, 1'b0);
    chk("R1", "fifoFreeze", fifoFreeze, 1'b0);
    seqMode = 2'b01; traceEn = 1;
    #1;
    chk("R1", "traceCntEn unarmed", traceCntEn, 1'b0);
  endtask

  task automatic t_mode_off();
    do_reset();
    traceEn = 1;
    #1;
    chk("R2", "traceCntEn follows traceEn", traceCntEn, 1'b1);
    matchA = 1;
    tick();
    chk("R2", "A request", dbgReq, 1'b1);
    matchA = 0; matchB = 1;
    tick();
    chk("R2", "B request", dbgReq, 1'b1);
    matchB = 0;
    tick();
    chk("R2", "request drops", dbgReq, 1'b0);
  endtask

  task automatic t_mode_b_trace();
    do_reset();
    seqMode = 2'b01; traceEn = 1;
    tick();
    chk("R3", "trace held before B", traceCntEn, 1'b0);
    matchB = 1;
    #1;
    chk("R3", "trace still held in B cycle", traceCntEn, 1'b0);
    tick();
    matchB = 0;
    chk("R3", "B no request", dbgReq, 1'b0);
    #1;
    chk("R3", "trace released", traceCntEn, 1'b1);
    matchA = 1;
    tick();
    matchA = 0;
    chk("R3", "A still requests", dbgReq, 1'b1);
    traceEn = 0;
    #1;
    chk("R6", "traceEn low gates trace", traceCntEn, 1'b0);
  endtask

  task automatic t_mode_a_b();
    do_reset();
    seqMode = 2'b10;
    tick();
    matchB = 1;
    tick();
    chk("R4", "B before A ignored", dbgReq, 1'b0);
    matchA = 1;
    tick();
    chk("R4", "A and same-cycle B no request", dbgReq, 1'b0);
    matchA = 0;
    tick();
    chk("R4", "armed B requests", dbgReq, 1'b1);
    matchB = 0;
  endtask

  task automatic t_mode_chain();
    do_reset();
    seqMode = 2'b11; traceEn = 1;
    tick();
    matchA = 1; matchB = 1;
    tick();
    matchA = 0; matchB = 0;
    chk("R5", "no request from A", dbgReq, 1'b0);
    #1;
    chk("R5", "same-cycle B not counted", traceCntEn, 1'b0);
    tick();
    chk("R5", "still unarmed", traceCntEn, 1'b0);
    matchB = 1;
    tick();
    matchB = 0;
    chk("R5", "no request from B", dbgReq, 1'b0);
    chk("R5", "no freeze from B", freezeFlag, 1'b0);
    #1;
    chk("R5", "trace enabled after A then B", traceCntEn, 1'b1);
    traceEn = 0;
    #1;
    chk("R6", "traceEn low in chained mode", traceCntEn, 1'b0);
  endtask

  task automatic t_freeze();
    do_reset();
    freezeSel = 1; matchB = 1;
    tick();
    matchB = 0;
    chk("R7", "freeze no request", dbgReq, 1'b0);
    chk("R7", "freezeFlag set", freezeFlag, 1'b1);
    chk("R7", "fifoFreeze set", fifoFreeze, 1'b1);
    repeat (3) tick();
    chk("R8", "freeze sticky", fifoFreeze, 1'b1);
    freezeClr = 1; matchB = 1;
    tick();
    chk("R8", "set wins over clear", freezeFlag, 1'b1);
    matchB = 0;
    tick();
    freezeClr = 0;
    chk("R8", "cleared flag", freezeFlag, 1'b0);
    chk("R8", "cleared freeze", fifoFreeze, 1'b0);
  endtask

  task automatic t_force();
    do_reset();
    forceDbg = 1;
    tick();
    chk("R9", "force first cycle", dbgReq, 1'b1);
    tick();
    chk("R9", "force held", dbgReq, 1'b1);
    forceDbg = 0;
    tick();
    chk("R9", "force released", dbgReq, 1'b0);
  endtask

  task automatic t_int();
    do_reset();
    intReq = 1;
    tick();
    chk("R10", "gated internal request", dbgReq, 1'b0);
    intReqEn = 1;
    tick();
    chk("R10", "enabled internal request", dbgReq, 1'b1);
    intReq = 0;
  endtask

  task automatic t_term();
    do_reset();
    seqMode = 2'b01; traceEn = 1;
    tick();
    traceTerm = 1;
    tick();
    traceTerm = 0;
    chk("R11", "terminal ignored while trace held", dbgReq, 1'b0);
    matchB = 1;
    tick();
    matchB = 0; traceTerm = 1;
    tick();
    traceTerm = 0;
    chk("R11", "terminal requests while counting", dbgReq, 1'b1);
  endtask

  task automatic t_mode_change();
    do_reset();
    seqMode = 2'b01; traceEn = 1;
    tick();
    matchB = 1;
    tick();
    matchB = 0;
    #1;
    chk("R12", "armed before change", traceCntEn, 1'b1);
    seqMode = 2'b11;
    tick();
    seqMode = 2'b01;
    #1;
    chk("R12", "flags clear in change cycle", traceCntEn, 1'b0);
    tick();
    chk("R12", "flags stay clear", traceCntEn, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_mode_off();
    t_mode_b_trace();
    t_mode_a_b();
    t_mode_chain();
    t_freeze();
    t_force();
    t_int();
    t_term();
    t_mode_change();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule